// File: doc/BRIEF.md
# Eight-Line Fixed-Priority Interrupt Controller

This block collects up to eight interrupt request lines and presents them to a processor through a single interrupt output. A rising edge on a line records a pending request. A mask register can hold a request back without losing it. A fixed-priority resolver picks the winner, and line 0 is the most urgent. An in-service register remembers which lines the processor is currently handling, and it keeps requests of equal or lower urgency from interrupting that handler.

The processor answers the interrupt output with two acknowledge pulses on `ack_pulse`, each one clock cycle wide. On the first pulse the winning request moves into the in-service register. On the second pulse the block returns an 8-bit handler vector for one cycle, made of a programmable 5-bit base and the 3-bit line number. If nothing is eligible at the first pulse, the block answers with line 7 and records no in-service bit. A small write port sets the mask, sets the vector base and issues a non-specific end-of-interrupt command.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `cpu_int` and `vec_valid` are 0. The request, in-service and mask registers and the vector base are all zero.
- R2: A 0-to-1 transition of `irq_line[n]` sets request bit n at the next clock edge. A line that stays high raises no further request after its request has been acknowledged.
- R3: A request whose mask bit is 1 stays pending but does not drive `cpu_int`. Clearing the mask bit lets it raise `cpu_int` without a new edge. The mask is written with `reg_sel`=0, and `reg_wdata[n]` masks line n.
- R4: When several eligible requests are pending, the lowest line number wins.
- R5: The first acknowledge pulse sets the winner's in-service bit and clears its request bit.
- R6: The second acknowledge pulse makes `vec_valid` high for exactly one cycle, starting the cycle after that pulse. `vec_data` is then {base, line number}, where the base is `reg_wdata[7:3]` written with `reg_sel`=1.
- R7: `cpu_int` is high only while some unmasked pending request has a strictly lower line number than every set in-service bit.
- R8: A write with `reg_sel`=2 clears only the set in-service bit with the lowest line number.
- R9: If no request is eligible at the first acknowledge pulse, the vector returned carries line number 7 and no in-service bit is set.
- R10: A write with `reg_sel`=3 changes neither the mask nor the vector base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | 8 | Edge-triggered request lines, bit n is line n |
| ack_pulse | input | 1 | One-cycle acknowledge pulse, issued twice per interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 mask, 1 vector base, 2 end-of-interrupt, 3 none |
| reg_wdata | input | 8 | Write data |
| cpu_int | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector on `vec_data` is valid this cycle |
| vec_data | output | 8 | Handler vector {base, line number} |

## Verification
The hardest case to reach is the spurious acknowledge, because the processor has already seen `cpu_int` high. The bench brings it about by raising a line and then masking that line between the interrupt and the first pulse. It then checks that the vector carries line 7. It also checks that a fresh edge on line 7 still raises `cpu_int`, which shows that no in-service bit was recorded. Nested service works the same way. A low-urgency handler is interrupted by a higher one, and two end-of-interrupt commands retire the two handlers in turn. A still-pending lower request stays silent until the outer handler is cleared.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   typedef enum logic [1:0] {
      SEL_MASK = 2'd0,
      SEL_BASE = 2'd1,
      SEL_EOI  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   typedef enum logic {
      PH_IDLE     = 1'b0,
      PH_WAIT_VEC = 1'b1
   } ack_phase_e;

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int N   = 8,
   parameter int IDW = $clog2(N)
) (
   input  logic [N-1:0]   req,
   output logic [N-1:0]   onehot,
   output logic [IDW-1:0] idx,
   output logic           any
);
   logic [N-1:0] seen;

   for (genvar i = 0; i < N; i++) begin : g_seen
      if (i == 0) begin : g_first
         assign seen[i] = 1'b0;
      end else begin : g_rest
         assign seen[i] = seen[i-1] | req[i-1];
      end
   end

   assign onehot = req & ~seen;
   assign any    = |req;

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (onehot[i]) idx = i[IDW-1:0];
      end
   end
endmodule

// File: rtl/irq_edge_req.sv
module irq_edge_req #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] line,
   input  logic [N-1:0] clr,
   output logic [N-1:0] req_q
);
   logic [N-1:0] line_d;
   logic [N-1:0] rise;

   assign rise = line & ~line_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_d <= '0;
         req_q  <= '0;
      end else begin
         line_d <= line;
         req_q  <= (req_q & ~clr) | rise;
      end
   end

   // R2
   req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|rise) |=> ((req_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/irq_svc_reg.sv
module irq_svc_reg #(
   parameter int N   = 8,
   parameter int IDW = $clog2(N)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic         eoi,
   output logic [N-1:0] isr_q,
   output logic [N-1:0] allow
);
   logic [N-1:0]   blk;
   logic [N-1:0]   top_onehot;
   logic [IDW-1:0] top_idx;
   logic           top_any;
   logic [N-1:0]   eoi_clr;

   for (genvar i = 0; i < N; i++) begin : g_blk
      if (i == 0) begin : g_first
         assign blk[i] = isr_q[i];
      end else begin : g_rest
         assign blk[i] = blk[i-1] | isr_q[i];
      end
   end
   assign allow = ~blk;

   irq_pick #(.N(N), .IDW(IDW)) u_top (
      .req    (isr_q),
      .onehot (top_onehot),
      .idx    (top_idx),
      .any    (top_any)
   );

   assign eoi_clr = eoi ? top_onehot : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= (isr_q | set_vec) & ~eoi_clr;
   end

   // R5
   isr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec) |=> ((isr_q & $past(set_vec)) == $past(set_vec)));

   // R8
   eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && top_any) |=> (isr_q[$past(top_idx)] == 1'b0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int N_LINES = 8,
   parameter int VEC_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] irq_line,
   input  logic               ack_pulse,
   input  logic               reg_wr,
   input  logic [1:0]         reg_sel,
   input  logic [VEC_W-1:0]   reg_wdata,
   output logic               cpu_int,
   output logic               vec_valid,
   output logic [VEC_W-1:0]   vec_data
);
   localparam int ID_W   = $clog2(N_LINES);
   localparam int BASE_W = VEC_W - ID_W;
   localparam logic [ID_W-1:0] SPUR_ID = ID_W'(N_LINES - 1);

   if (N_LINES < 2 || (1 << ID_W) != N_LINES) begin : g_bad_lines
      $error("N_LINES must be a power of two of at least 2");
   end
   if (VEC_W <= ID_W || VEC_W < N_LINES) begin : g_bad_vec
      $error("VEC_W must exceed the line-number width and cover the mask");
   end

   logic [N_LINES-1:0] req_q, mask_q, isr_q, allow, elig;
   logic [N_LINES-1:0] win_onehot, take_vec;
   logic [ID_W-1:0]    win_idx, held_id;
   logic               win_any, first_ack, second_ack, eoi_cmd;
   logic [BASE_W-1:0]  base_q;
   ack_phase_e         phase_q;
   reg_sel_e           sel;

   assign sel = reg_sel_e'(reg_sel);

   irq_edge_req #(.N(N_LINES)) u_req (
      .clk   (clk),
      .rst_n (rst_n),
      .line  (irq_line),
      .clr   (take_vec),
      .req_q (req_q)
   );

   irq_svc_reg #(.N(N_LINES), .IDW(ID_W)) u_svc (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (take_vec),
      .eoi     (eoi_cmd),
      .isr_q   (isr_q),
      .allow   (allow)
   );

   assign elig = req_q & ~mask_q & allow;

   irq_pick #(.N(N_LINES), .IDW(ID_W)) u_win (
      .req    (elig),
      .onehot (win_onehot),
      .idx    (win_idx),
      .any    (win_any)
   );

   assign cpu_int    = win_any;
   assign first_ack  = ack_pulse && (phase_q == PH_IDLE);
   assign second_ack = ack_pulse && (phase_q == PH_WAIT_VEC);
   assign take_vec   = first_ack ? win_onehot : '0;
   assign eoi_cmd    = reg_wr && (sel == SEL_EOI);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         base_q <= '0;
      end else if (reg_wr) begin
         if (sel == SEL_MASK) mask_q <= reg_wdata[N_LINES-1:0];
         if (sel == SEL_BASE) base_q <= reg_wdata[VEC_W-1:ID_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         held_id   <= '0;
         vec_valid <= 1'b0;
         vec_data  <= '0;
      end else begin
         vec_valid <= second_ack;
         if (first_ack) begin
            phase_q <= PH_WAIT_VEC;
            held_id <= win_any ? win_idx : SPUR_ID;
         end
         if (second_ack) begin
            phase_q  <= PH_IDLE;
            vec_data <= {base_q, held_id};
         end
      end
   end

   // R6
   vec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |=> !vec_valid);

   // R6
   vec_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      second_ack |=> (vec_data[ID_W-1:0] == $past(held_id)));

   // R9
   spur_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (first_ack && !win_any) |=> (held_id == SPUR_ID));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_line = '0;
   logic       ack_pulse = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_sel = '0;
   logic [7:0] reg_wdata = '0;
   logic       cpu_int, vec_valid;
   logic [7:0] vec_data;

   int errors = 0;
   int checks = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;

   prio_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .ack_pulse(ack_pulse),
      .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .cpu_int(cpu_int), .vec_valid(vec_valid), .vec_data(vec_data)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_int(input logic exp, input string tag);
      check({7'b0, cpu_int}, {7'b0, exp}, tag);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic raise(input int n);
      irq_line[n] = 1'b1;
      step();
   endtask

   // two-pulse acknowledge; expected vector pushed into the scoreboard
   task automatic ack_seq(input logic [7:0] exp_vec, input string tag);
      ack_pulse = 1'b1;
      step();
      ack_pulse = 1'b0;
      step();
      ack_pulse = 1'b1;
      exp_q.push_back(exp_vec);
      tag_q.push_back(tag);
      step();
      ack_pulse = 1'b0;
      step();
      check({7'b0, vec_valid}, 8'h00, "R6 vec_valid one cycle");
   endtask

   // monitor: pops the scoreboard whenever a vector appears
   always @(negedge clk) begin
      if (rst_n && vec_valid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R6: unexpected vector actual=%h expected=none", vec_data);
         end else begin
            check(vec_data, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   initial begin
      #(8 * 100000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      step(); step();
      // R1 reset state
      chk_int(1'b0, "R1 int after reset");
      check({7'b0, vec_valid}, 8'h00, "R1 vec_valid after reset");
      check(vec_data, 8'h00, "R1 vec_data after reset");
      rst_n = 1'b1;
      step();
      chk_int(1'b0, "R1 int idle");

      // R2 edge sets request; R5 ack clears it
      raise(3);
      chk_int(1'b1, "R2 edge raises int");
      ack_seq(8'h03, "R5 R6 vector line 3 base 0");
      chk_int(1'b0, "R5 request cleared");
      wr(2, 8'h00);
      step();
      chk_int(1'b0, "R2 held level no new request");
      irq_line = '0;
      step();

      // R4 priority with base
      wr(1, 8'hA8);
      irq_line[5] = 1'b1; irq_line[2] = 1'b1;
      step();
      chk_int(1'b1, "R4 two requests");
      ack_seq(8'hAA, "R4 line 2 wins");
      chk_int(1'b0, "R7 lower blocked by in-service");
      wr(2, 8'h00);
      chk_int(1'b1, "R8 eoi releases line 5");
      ack_seq(8'hAD, "R6 line 5 vector");
      wr(2, 8'h00);
      irq_line = '0;
      step();

      // R7 nesting, R8 eoi order
      raise(4);
      ack_seq(8'hAC, "R7 line 4");
      raise(6);
      chk_int(1'b0, "R7 line 6 blocked");
      raise(1);
      chk_int(1'b1, "R7 higher line 1 raises int");
      ack_seq(8'hA9, "R7 nested line 1");
      wr(2, 8'h00);
      chk_int(1'b0, "R8 only line 1 cleared, line 4 still in service");
      wr(2, 8'h00);
      chk_int(1'b1, "R8 line 4 cleared, line 6 eligible");
      ack_seq(8'hAE, "R8 line 6 vector");
      wr(2, 8'h00);
      irq_line = '0;
      step();

      // R3 mask
      wr(0, 8'h01);
      raise(0);
      chk_int(1'b0, "R3 masked request silent");
      wr(0, 8'h00);
      chk_int(1'b1, "R3 unmask raises int");
      ack_seq(8'hA8, "R3 line 0 vector");
      wr(2, 8'h00);
      irq_line = '0;
      step();

      // R9 spurious
      raise(3);
      chk_int(1'b1, "R9 line 3 pending");
      wr(0, 8'h08);
      chk_int(1'b0, "R9 masked before ack");
      ack_seq(8'hAF, "R9 spurious vector line 7");
      raise(7);
      chk_int(1'b1, "R9 no in-service bit set");
      ack_seq(8'hAF, "R9 real line 7");
      wr(2, 8'h00);
      wr(0, 8'h00);
      chk_int(1'b1, "R3 line 3 still pending");
      ack_seq(8'hAB, "R3 line 3 vector");
      wr(2, 8'h00);
      irq_line = '0;
      step();

      // R10 ignored select
      wr(3, 8'hFF);
      raise(2);
      chk_int(1'b1, "R10 mask unchanged");
      ack_seq(8'hAA, "R10 base unchanged");
      wr(2, 8'h00);
      step(); step();

      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R6: missing vectors actual=%0d expected=0", exp_q.size());
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule